// File: doc/BRIEF.md
# GHASH Multiply-Accumulate Unit

This unit carries out the GHASH step of a vector crypto operation over a run of 128-bit element groups. Each group is four 32-bit elements. Software places an accumulator, a hash subkey and a data block in vector registers, and a sequencer streams them in as 64-bit low and high halves. For each group the unit forms the carry-less product of accumulator and subkey in GF(2^128) under the GCM field polynomial. It then XORs that product with the data block and returns the 128-bit result.

A start pulse latches the vector length, the start element, the element-width selector and the tail policy. The unit first checks that the configuration is legal. It then requests one operand beat per group, from group `start/4` up to group `length/4 - 1`. Each product is built bit-serially, one multiplier bit per clock. After the last group, and only if the tail policy asks for it, the unit emits an all-ones beat for every remaining group up to the register capacity. A one-cycle `done` closes the operation.

Both data interfaces use valid/ready. An operand beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the unit is waiting for the next group's operands. A result beat is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and the result stay unchanged, so the consumer may stall for any length of time.

Top module: `ghash_mac_unit`

## Requirements
- R1: Result value. Let f(v) reverse the bit order inside every byte of v, where v is {hi, lo} with lo in bits 63:0. Let y = f(acc) and h = f(key). Let z start at 0. For j = 0 to 127: if y[j] is set, z ^= h; then h shifts left by one, and it is XORed with 0x87 when the bit that left position 127 was 1. The result {out_hi, out_lo} is f(z) XOR {in_data_hi, in_data_lo}.
- R2: `out_valid` for a group first goes high after the 129th rising edge that follows the edge on which its operands were accepted: 128 multiply steps plus one result register.
- R3: A configuration is illegal when any of these holds: the length is not a multiple of 4, the start element is not a multiple of 4, `cfg_ew32` is 0, or the length exceeds MAX_ELEMS. An illegal start gives `done`=1 with `err`=1 on the next cycle. No operand is requested and no result beat is produced.
- R4: A legal operation requests exactly `len/4 - start/4` operand beats, one per group, in ascending group order. When start >= len it requests none.
- R5: When `cfg_tail_ones` is 1, the unit emits one beat after the last group for each group index from len/4 to MAX_ELEMS/4-1. Each such beat has `out_tail`=1 and all 128 result bits set. When `cfg_tail_ones` is 0, it emits no such beats. Group result beats carry `out_tail`=0.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_lo` and `out_hi` stay unchanged.
- R7: After reset, `busy`, `done`, `in_ready` and `out_valid` are 0. `busy` is 1 from the edge that accepts a start until `done` has been shown. `done` is a single-cycle pulse, and it appears on the cycle after the final result beat is handed over, or on the cycle after start when there are no beats. `err` is 0 after a legal operation.
- R8: A start pulse while `busy` is 1 has no effect. The running operation keeps its beat count, and no further operation begins after its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled only when idle) |
| cfg_vlen | input | CNT_W | Vector length in 32-bit elements |
| cfg_vstart | input | CNT_W | First element to process |
| cfg_ew32 | input | 1 | Selected element width is 32 bits |
| cfg_tail_ones | input | 1 | Fill tail groups with all-ones beats |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal configuration, valid with done |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Unit accepts an operand beat |
| in_acc_lo | input | HALF_W | Accumulator, low half |
| in_acc_hi | input | HALF_W | Accumulator, high half |
| in_key_lo | input | HALF_W | Hash subkey, low half |
| in_key_hi | input | HALF_W | Hash subkey, high half |
| in_data_lo | input | HALF_W | Data block, low half |
| in_data_hi | input | HALF_W | Data block, high half |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_lo | output | HALF_W | Result, low half |
| out_hi | output | HALF_W | Result, high half |
| out_tail | output | 1 | Beat is a tail fill, not a group result |

## Verification
The bench builds the unit with its defaults: 32-bit elements, four elements per group and a capacity of 32 elements, so there are eight groups and length and start fields are 6 bits wide. With eight groups, one bench can reach a full-length run, a run of only the last group with no tail left, and runs with no groups where the whole register is tail fill. The 6-bit length field can also hold the value 36, which exercises the over-capacity rejection next to the misaligned and wrong-width cases.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_MUL  = 3'd2,
    ST_OUT  = 3'd3,
    ST_TAIL = 3'd4,
    ST_FIN  = 3'd5
  } seq_state_e;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/ghash_byte_reflect.sv
module ghash_byte_reflect #(
  parameter int W = 128
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  import ghash_pkg::*;

  localparam int NBYTES = W / BYTE_BITS;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_BITS; i++) begin : g_bit
      assign dout[b*BYTE_BITS + i] = din[b*BYTE_BITS + (BYTE_BITS-1-i)];
    end
  end

endmodule

// File: rtl/ghash_bitserial_mul.sv
module ghash_bitserial_mul #(
  parameter int           W    = 128,
  parameter logic [W-1:0] POLY = W'(8'h87)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] op_y,
  input  logic [W-1:0] op_h,
  output logic         fin,
  output logic [W-1:0] prod
);
  localparam int           SC_W = $clog2(W);
  localparam logic [SC_W-1:0] LAST = SC_W'(W-1);

  logic [W-1:0]    acc_q, h_q, y_q;
  logic [SC_W-1:0] step_q;
  logic            run_q, fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      h_q    <= '0;
      y_q    <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else if (load) begin
      acc_q  <= '0;
      h_q    <= op_h;
      y_q    <= op_y;
      step_q <= '0;
      run_q  <= 1'b1;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (run_q) begin
        if (y_q[0]) acc_q <= acc_q ^ h_q;
        h_q    <= {h_q[W-2:0], 1'b0} ^ (h_q[W-1] ? POLY : '0);
        y_q    <= y_q >> 1;
        step_q <= step_q + SC_W'(1);
        if (step_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin  = fin_q;
  assign prod = acc_q;

  // R2: the final step is followed by the finish pulse
  p_fin_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q == LAST && !load) |=> (fin_q && !run_q));

  // R8: a new load never lands on a running product
  p_load_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !run_q);

endmodule

// File: rtl/ghash_seq_ctrl.sv
module ghash_seq_ctrl #(
  parameter int MAX_ELEMS = 32,
  parameter int GRP_ELEMS = 4,
  parameter int CNT_W     = $clog2(MAX_ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_vlen,
  input  logic [CNT_W-1:0] cfg_vstart,
  input  logic             cfg_ew32,
  input  logic             cfg_tail_ones,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             mul_fin,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             in_ready,
  output logic             mul_load,
  output logic             out_valid,
  output logic             out_tail,
  output logic             ld_prod,
  output logic             ld_ones
);
  import ghash_pkg::*;

  localparam int               GS     = $clog2(GRP_ELEMS);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_ELEMS);
  localparam logic [CNT_W-1:0] GMAX_C = CNT_W'(MAX_ELEMS / GRP_ELEMS);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] gidx_q, gidx_d, gend_q, gend_d;
  logic             tail_q, tail_d, err_q, err_d;
  logic             bad;
  logic [CNT_W-1:0] first_g, end_g, next_g;

  assign bad = (cfg_vlen[GS-1:0] != '0) || (cfg_vstart[GS-1:0] != '0) ||
               !cfg_ew32 || (cfg_vlen > MAX_C);
  assign first_g = cfg_vstart >> GS;
  assign end_g   = cfg_vlen >> GS;
  assign next_g  = gidx_q + CNT_W'(1);

  always_comb begin
    st_d      = st_q;
    gidx_d    = gidx_q;
    gend_d    = gend_q;
    tail_d    = tail_q;
    err_d     = err_q;
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_tail  = 1'b0;
    ld_prod   = 1'b0;
    ld_ones   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (bad) begin
          err_d = 1'b1;
          st_d  = ST_FIN;
        end else begin
          err_d  = 1'b0;
          gidx_d = first_g;
          gend_d = end_g;
          tail_d = cfg_tail_ones;
          if (first_g < end_g) begin
            st_d = ST_LOAD;
          end else if (cfg_tail_ones && end_g < GMAX_C) begin
            gidx_d  = end_g;
            st_d    = ST_TAIL;
            ld_ones = 1'b1;
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_LOAD: begin
        in_ready = 1'b1;
        if (in_valid) st_d = ST_MUL;
      end
      ST_MUL: if (mul_fin) begin
        ld_prod = 1'b1;
        st_d    = ST_OUT;
      end
      ST_OUT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          gidx_d = next_g;
          if (next_g < gend_q) begin
            st_d = ST_LOAD;
          end else if (tail_q && gend_q < GMAX_C) begin
            st_d    = ST_TAIL;
            ld_ones = 1'b1;
          end else begin
            st_d = ST_FIN;
          end
        end
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_tail  = 1'b1;
        if (out_ready) begin
          gidx_d = next_g;
          if (next_g >= GMAX_C) st_d = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      gidx_q <= '0;
      gend_q <= '0;
      tail_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      gidx_q <= gidx_d;
      gend_q <= gend_d;
      tail_q <= tail_d;
      err_q  <= err_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign err      = err_q;
  assign mul_load = in_ready && in_valid;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a rejected start finishes at once without any data movement
  p_illegal_fin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && bad) |=> (done && err && !in_ready && !out_valid));

  // R4: operands are only requested for groups inside the range
  p_grp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (gidx_q < gend_q));

  // R8: a start during a multiply leaves the group bookkeeping alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MUL && start) |=> ($stable(gend_q) && $stable(gidx_q)));

endmodule

// File: rtl/ghash_mac_unit.sv
module ghash_mac_unit #(
  parameter int               ELEM_W    = 32,
  parameter int               GRP_ELEMS = 4,
  parameter int               MAX_ELEMS = 32,
  parameter int               GRP_W     = ELEM_W * GRP_ELEMS,
  parameter int               HALF_W    = GRP_W / 2,
  parameter int               CNT_W     = $clog2(MAX_ELEMS + 1),
  parameter logic [GRP_W-1:0] RED_POLY  = GRP_W'(8'h87)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cfg_vlen,
  input  logic [CNT_W-1:0]  cfg_vstart,
  input  logic              cfg_ew32,
  input  logic              cfg_tail_ones,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_acc_lo,
  input  logic [HALF_W-1:0] in_acc_hi,
  input  logic [HALF_W-1:0] in_key_lo,
  input  logic [HALF_W-1:0] in_key_hi,
  input  logic [HALF_W-1:0] in_data_lo,
  input  logic [HALF_W-1:0] in_data_hi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_lo,
  output logic [HALF_W-1:0] out_hi,
  output logic              out_tail
);

  logic [GRP_W-1:0] y_ref, h_ref, prod, prod_ref, x_q, res_q;
  logic             mul_load, mul_fin, ld_prod, ld_ones;

  ghash_byte_reflect #(.W(GRP_W)) u_rev_y (
    .din ({in_acc_hi, in_acc_lo}),
    .dout(y_ref)
  );

  ghash_byte_reflect #(.W(GRP_W)) u_rev_h (
    .din ({in_key_hi, in_key_lo}),
    .dout(h_ref)
  );

  ghash_byte_reflect #(.W(GRP_W)) u_rev_z (
    .din (prod),
    .dout(prod_ref)
  );

  ghash_bitserial_mul #(.W(GRP_W), .POLY(RED_POLY)) u_mul (
    .clk  (clk),
    .rst_n(rst_n),
    .load (mul_load),
    .op_y (y_ref),
    .op_h (h_ref),
    .fin  (mul_fin),
    .prod (prod)
  );

  ghash_seq_ctrl #(
    .MAX_ELEMS(MAX_ELEMS),
    .GRP_ELEMS(GRP_ELEMS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_vlen     (cfg_vlen),
    .cfg_vstart   (cfg_vstart),
    .cfg_ew32     (cfg_ew32),
    .cfg_tail_ones(cfg_tail_ones),
    .in_valid     (in_valid),
    .out_ready    (out_ready),
    .mul_fin      (mul_fin),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .in_ready     (in_ready),
    .mul_load     (mul_load),
    .out_valid    (out_valid),
    .out_tail     (out_tail),
    .ld_prod      (ld_prod),
    .ld_ones      (ld_ones)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      res_q <= '0;
    end else begin
      if (mul_load) x_q <= {in_data_hi, in_data_lo};
      if (ld_prod)       res_q <= prod_ref ^ x_q;
      else if (ld_ones)  res_q <= '1;
    end
  end

  assign out_lo = res_q[HALF_W-1:0];
  assign out_hi = res_q[GRP_W-1:HALF_W];

  // R6: a stalled result beat keeps its value
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lo) && $stable(out_hi)));

endmodule

// File: tb/ghash_mac_unit_tb.sv
module ghash_mac_unit_tb;

  localparam int CW   = 6;
  localparam int NGRP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] cfg_vlen = '0, cfg_vstart = '0;
  logic          cfg_ew32 = 1'b1, cfg_tail_ones = 1'b0;
  logic          busy, done, err, in_ready, out_valid, out_tail;
  logic          in_valid = 1'b0, out_ready = 1'b0;
  logic [63:0]   a_lo = '0, a_hi = '0, k_lo = '0, k_hi = '0, d_lo = '0, d_hi = '0;
  logic [63:0]   out_lo, out_hi;

  int nchk = 0;
  int nfail = 0;
  bit ended = 1'b0;

  always #10 clk = ~clk;

  ghash_mac_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_vlen(cfg_vlen), .cfg_vstart(cfg_vstart),
    .cfg_ew32(cfg_ew32), .cfg_tail_ones(cfg_tail_ones),
    .busy(busy), .done(done), .err(err),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_acc_lo(a_lo), .in_acc_hi(a_hi),
    .in_key_lo(k_lo), .in_key_hi(k_hi),
    .in_data_lo(d_lo), .in_data_hi(d_hi),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lo(out_lo), .out_hi(out_hi), .out_tail(out_tail)
  );

  function automatic logic [127:0] refl(input logic [127:0] v);
    logic [127:0] r;
    for (int b = 0; b < 16; b++)
      for (int i = 0; i < 8; i++) r[b*8+i] = v[b*8+7-i];
    return r;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, k, d);
    logic [127:0] y, h, z;
    logic red;
    y = refl(a); h = refl(k); z = '0;
    for (int j = 0; j < 128; j++) begin
      if (y[j]) z ^= h;
      red = h[127];
      h = h << 1;
      if (red) h ^= 128'h87;
    end
    return refl(z) ^ d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  // patterns: 0 random, 1 key zero, 2 acc zero, 3 all ones, 4 unit acc
  task automatic gen_ops(input int pat);
    a_lo = {$urandom, $urandom}; a_hi = {$urandom, $urandom};
    k_lo = {$urandom, $urandom}; k_hi = {$urandom, $urandom};
    d_lo = {$urandom, $urandom}; d_hi = {$urandom, $urandom};
    case (pat)
      1: begin k_lo = '0; k_hi = '0; end
      2: begin a_lo = '0; a_hi = '0; end
      3: begin a_lo = '1; a_hi = '1; k_lo = '1; k_hi = '1; d_lo = '1; d_hi = '1; end
      4: begin a_lo = 64'h80; a_hi = '0; end
      default: ;
    endcase
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !in_ready && !out_valid, "R7", "reset state",
        {busy, done, in_ready, out_valid}, 0);
  endtask

  task automatic t_vector(input int vl, input int vs, input bit tail,
                          input int pat, input int stall);
    int first, last, beats;
    logic [127:0] exp, got, held;
    first = vs / 4; last = vl / 4; beats = 0;
    cfg_vlen = CW'(vl); cfg_vstart = CW'(vs); cfg_ew32 = 1'b1; cfg_tail_ones = tail;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    for (int g = first; g < last; g++) begin
      int n;
      while (!in_ready) @(negedge clk);
      gen_ops(pat);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      exp = model({a_hi, a_lo}, {k_hi, k_lo}, {d_hi, d_lo});
      if (pat == 1 || pat == 2) exp = {d_hi, d_lo};
      if (pat == 4) exp = {k_hi, k_lo} ^ {d_hi, d_lo};
      n = 0;
      while (!out_valid) begin
        @(negedge clk);
        n++;
        start = (n == 5);   // R8: start during a busy multiply
        cfg_vlen = CW'(n == 5 ? 4 : vl);
      end
      start = 1'b0;
      cfg_vlen = CW'(vl);
      chk(n == 129, "R2", "latency", n, 129);
      got = {out_hi, out_lo};
      chk(got == exp, "R1", "group result", got, exp);
      chk(!out_tail, "R5", "tail flag on group beat", out_tail, 0);
      held = got;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(out_valid && {out_hi, out_lo} == held, "R6", "stalled beat",
            {out_hi, out_lo}, held);
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      beats++;
    end
    chk(beats == ((vs < vl) ? last - first : 0), "R4", "operand beats", beats,
        (vs < vl) ? last - first : 0);
    if (tail) begin
      for (int t = last; t < NGRP; t++) begin
        while (!out_valid) @(negedge clk);
        chk(out_tail && {out_hi, out_lo} == '1, "R5", "tail beat",
            {out_hi, out_lo}, '1);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
      end
    end
    chk(done && !err && !out_valid && !in_ready, "R7", "done after last beat",
        {done, err, out_valid, in_ready}, 4'b1000);
    @(negedge clk);
    chk(!done && !busy, "R7", "done is one cycle", {done, busy}, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !in_ready && !out_valid, "R8", "no op launched by busy start",
          {busy, in_ready, out_valid}, 0);
    end
  endtask

  task automatic t_illegal(input int vl, input int vs, input bit ew);
    cfg_vlen = CW'(vl); cfg_vstart = CW'(vs); cfg_ew32 = ew; cfg_tail_ones = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && err && !in_ready && !out_valid, "R3", "illegal rejected",
        {done, err, in_ready, out_valid}, 4'b1100);
    repeat (3) begin
      @(negedge clk);
      chk(!done && !busy && !in_ready && !out_valid, "R3", "no activity after reject",
          {done, busy, in_ready, out_valid}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_vector(32, 0, 1'b0, 0, 0);   // R1 R4 full length random
    t_vector(16, 0, 1'b0, 1, 0);   // R1 key zero
    t_vector(16, 4, 1'b0, 2, 2);   // R1 R6 acc zero, start group 1
    t_vector(8, 0, 1'b0, 3, 0);    // R1 all ones
    t_vector(12, 8, 1'b1, 4, 1);   // R1 R5 unit acc, tail fill
    t_vector(32, 28, 1'b1, 0, 3);  // R4 R5 last group only, no tail left
    t_vector(8, 8, 1'b1, 0, 0);    // R4 R5 no groups, tail only
    t_vector(4, 8, 1'b0, 0, 0);    // R4 start beyond length
    t_illegal(6, 0, 1'b1);         // R3 length misaligned
    t_illegal(8, 2, 1'b1);         // R3 start misaligned
    t_illegal(8, 0, 1'b0);         // R3 element width
    t_illegal(36, 0, 1'b1);        // R3 over capacity
    t_vector(16, 0, 1'b0, 0, 1);   // recovery after rejects
    finish_run();
  end

endmodule